// File: doc/BRIEF.md
# PWM Shadow Register Update Controller

This block sits between a register write bus and a two-output PWM generator. It holds four 12-bit compare values, an output-configuration field and a mode field in holding registers. It copies them into the active registers that the waveform logic uses, so that a new set of timing values always takes effect as one consistent set and never part-way through a period.

When the generator is stopped, a committed write goes straight through to the active register. When the generator is running, values are held until an end-of-cycle pulse from the counter, and then all six fields are copied together. A manual lock can defer that copy. An auto-lock policy can instead wait until software has written the high byte of the reset-B compare. A mirror mode makes output A reuse output B's compare pair, so software need not program the A compares.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every active output is zero, and lock, auto-lock, mirror and the pending flag are clear.
- R2: Compare k (0 = set-A, 1 = reset-A, 2 = set-B, 3 = reset-B) takes its low byte at address 2k and its high nibble from data bits [3:0] at address 2k+1. Only the high write commits the 12-bit holding value {high, low}. Address 8 is the output configuration (data bits [3:0]), address 9 is the mode (data bits [1:0]), and address 10 is control (bit 0 lock, bit 1 auto-lock, bit 2 mirror).
- R3: While `run` is low, a committing write to a buffered field appears on that field's active output one clock later, and `eoc` has no effect.
- R4: While `run` is high and neither lock policy applies, active outputs change only on an `eoc` clock, where all six fields take their holding values together.
- R5: With lock set (auto-lock not in effect), an `eoc` transfers nothing. After lock is cleared, the next `eoc` transfers the whole pending set.
- R6: With auto-lock in effect, an `eoc` transfers only if a reset-B high-byte write has occurred while running since the last transfer. Writes to other fields alone do not trigger it.
- R7: When auto-lock is in effect, the lock bit is ignored.
- R8: A change of the auto-lock bit is sampled at the next `eoc` pulse and governs only the `eoc` pulses after that one.
- R9: With mirror set, the set-A and reset-A outputs show the active set-B and reset-B values.
- R10: When a buffered write and a transferring `eoc` fall in the same clock, the transfer carries the holding value from before the write, and the new value waits for a later transfer.
- R11: After an auto-lock transfer, a later `eoc` with no new reset-B high-byte write transfers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data byte |
| run | input | 1 | Generator running (1) or stopped (0) |
| eoc | input | 1 | End-of-cycle pulse from the counter |
| act_set_a | output | 12 | Active set compare, output A |
| act_rst_a | output | 12 | Active reset compare, output A |
| act_set_b | output | 12 | Active set compare, output B |
| act_rst_b | output | 12 | Active reset compare, output B |
| act_cfg | output | 4 | Active output configuration |
| act_mode | output | 2 | Active mode field |

## Verification
The hardest situations to reach are the clocks where policy state and a pulse meet. One is the first `eoc` after auto-lock is enabled, which must still follow the old policy. Another is a reset-B high-byte write landing on a transferring `eoc`. The stimulus gets there by a fixed script. It first arms a full holding set, then toggles the control bits one clock before chosen `eoc` pulses, and finally drives a write and `eoc` in the same cycle. A behavioural model is compared with every output on every clock throughout.

// File: rtl/pwm_shadow_pkg.sv
// Package: shared field indices, address map and control bit positions
// for the PWM shadow register update controller.
package pwm_shadow_pkg;
    localparam int NCMP   = 4;  // compare registers
    localparam int NFIELD = 6;  // compares + configuration + mode
    localparam int ADDR_W = 4;

    localparam int F_SET_A = 0;
    localparam int F_RST_A = 1;
    localparam int F_SET_B = 2;
    localparam int F_RST_B = 3;
    localparam int F_CFG   = 4;
    localparam int F_MODE  = 5;

    localparam logic [ADDR_W-1:0] ADDR_RSTB_HI = 4'd7;
    localparam logic [ADDR_W-1:0] ADDR_CFG     = 4'd8;
    localparam logic [ADDR_W-1:0] ADDR_MODE    = 4'd9;
    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 4'd10;

    localparam int CTRL_LOCK  = 0;
    localparam int CTRL_ALOCK = 1;
    localparam int CTRL_MIRR  = 2;
endpackage

// File: rtl/pwm_shadow_hold.sv
// Holding bank: stages compare low bytes and commits full values on the
// high-byte write (or on the single configuration/mode write).
// Assumes 8 < CMP_W <= 16 and CFG_W, MODE_W <= 8.
module pwm_shadow_hold
    import pwm_shadow_pkg::*;
#(
    parameter int CMP_W  = 12,
    parameter int CFG_W  = 4,
    parameter int MODE_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [7:0]                    wr_data,
    output logic [NFIELD-1:0]             commit,
    output logic [CMP_W-1:0]              commit_val,
    output logic [NFIELD-1:0][CMP_W-1:0]  hold_q
);
    localparam int HI_W = CMP_W - 8;

    logic [7:0] lo_q [NCMP];

    // Decode which field a write commits this clock.
    always_comb begin
        commit = '0;
        for (int k = 0; k < NCMP; k++)
            commit[k] = wr_en && (wr_addr == ADDR_W'(2 * k + 1));
        commit[F_CFG]  = wr_en && (wr_addr == ADDR_CFG);
        commit[F_MODE] = wr_en && (wr_addr == ADDR_MODE);
    end

    // Form the value being committed, zero-extended to CMP_W.
    always_comb begin
        commit_val = '0;
        if (wr_addr == ADDR_CFG)
            commit_val[CFG_W-1:0] = wr_data[CFG_W-1:0];
        else if (wr_addr == ADDR_MODE)
            commit_val[MODE_W-1:0] = wr_data[MODE_W-1:0];
        else
            commit_val = {wr_data[HI_W-1:0], lo_q[wr_addr[2:1]]};
    end

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        // Stage the low byte of compare k.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lo_q[k] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(2 * k))
                lo_q[k] <= wr_data;
        end
    end

    for (genvar f = 0; f < NFIELD; f++) begin : g_hold
        // Keep the last committed value of field f.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[f] <= '0;
            else if (commit[f])
                hold_q[f] <= commit_val;
        end
    end
endmodule

// File: rtl/pwm_shadow_policy.sv
// Transfer policy: holds the control bits, the end-of-cycle-sampled
// auto-lock, the sticky pending flag, and decides when the set moves.
// Assumes eoc is a single-clock pulse.
module pwm_shadow_policy
    import pwm_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              run,
    input  logic              eoc,
    output logic              xfer,
    output logic              lock_q,
    output logic              al_eff_q,
    output logic              pend_q,
    output logic              mirror_q
);
    logic al_req_q;

    // Control register written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b0;
            al_req_q <= 1'b0;
            mirror_q <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            lock_q   <= wr_data[CTRL_LOCK];
            al_req_q <= wr_data[CTRL_ALOCK];
            mirror_q <= wr_data[CTRL_MIRR];
        end
    end

    // Auto-lock becomes effective only at an end-of-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            al_eff_q <= 1'b0;
        else if (eoc)
            al_eff_q <= al_req_q;
    end

    // Auto-lock wins over lock; otherwise lock vetoes the transfer.
    assign xfer = run && eoc && (al_eff_q ? pend_q : !lock_q);

    // Sticky trigger: set by a running reset-B high write, cleared by transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (run && wr_en && wr_addr == ADDR_RSTB_HI)
            pend_q <= 1'b1;
        else if (xfer)
            pend_q <= 1'b0;
    end
endmodule

// File: rtl/pwm_shadow_active.sv
// Active bank: loads all fields on a transfer, or one field straight
// from the bus while stopped; applies the mirror selection at the output.
// Assumes xfer is only asserted while running.
module pwm_shadow_active
    import pwm_shadow_pkg::*;
#(
    parameter int CMP_W  = 12,
    parameter int CFG_W  = 4,
    parameter int MODE_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    input  logic                          xfer,
    input  logic                          mirror,
    input  logic [NFIELD-1:0]             commit,
    input  logic [CMP_W-1:0]              commit_val,
    input  logic [NFIELD-1:0][CMP_W-1:0]  hold_q,
    output logic [CMP_W-1:0]              act_set_a,
    output logic [CMP_W-1:0]              act_rst_a,
    output logic [CMP_W-1:0]              act_set_b,
    output logic [CMP_W-1:0]              act_rst_b,
    output logic [CFG_W-1:0]              act_cfg,
    output logic [MODE_W-1:0]             act_mode
);
    logic [NFIELD-1:0][CMP_W-1:0] act_q;

    for (genvar f = 0; f < NFIELD; f++) begin : g_act
        // Update field f from the holding set or the stopped-mode write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                act_q[f] <= '0;
            else if (xfer)
                act_q[f] <= hold_q[f];
            else if (!run && commit[f])
                act_q[f] <= commit_val;
        end
    end

    // Output view, with output A borrowing output B's pair in mirror mode.
    always_comb begin
        act_set_b = act_q[F_SET_B];
        act_rst_b = act_q[F_RST_B];
        act_set_a = mirror ? act_q[F_SET_B] : act_q[F_SET_A];
        act_rst_a = mirror ? act_q[F_RST_B] : act_q[F_RST_A];
        act_cfg   = act_q[F_CFG][CFG_W-1:0];
        act_mode  = act_q[F_MODE][MODE_W-1:0];
    end
endmodule

// File: rtl/pwm_shadow_ctrl.sv
// Top: double-buffered compare/configuration set for a two-output PWM.
// Connects the holding bank, the transfer policy and the active bank.
// Assumes a single write port and an end-of-cycle pulse from the counter.
module pwm_shadow_ctrl
    import pwm_shadow_pkg::*;
#(
    parameter int CMP_W  = 12,
    parameter int CFG_W  = 4,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              run,
    input  logic              eoc,
    output logic [CMP_W-1:0]  act_set_a,
    output logic [CMP_W-1:0]  act_rst_a,
    output logic [CMP_W-1:0]  act_set_b,
    output logic [CMP_W-1:0]  act_rst_b,
    output logic [CFG_W-1:0]  act_cfg,
    output logic [MODE_W-1:0] act_mode
);
    logic [NFIELD-1:0]            commit;
    logic [CMP_W-1:0]             commit_val;
    logic [NFIELD-1:0][CMP_W-1:0] hold_q;
    logic xfer, lock_q, al_eff_q, pend_q, mirror_q;

    pwm_shadow_hold #(.CMP_W(CMP_W), .CFG_W(CFG_W), .MODE_W(MODE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .commit_val(commit_val),
        .hold_q(hold_q)
    );

    pwm_shadow_policy u_policy (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run(run), .eoc(eoc), .xfer(xfer),
        .lock_q(lock_q), .al_eff_q(al_eff_q), .pend_q(pend_q),
        .mirror_q(mirror_q)
    );

    pwm_shadow_active #(.CMP_W(CMP_W), .CFG_W(CFG_W), .MODE_W(MODE_W)) u_active (
        .clk(clk), .rst_n(rst_n), .run(run), .xfer(xfer), .mirror(mirror_q),
        .commit(commit), .commit_val(commit_val), .hold_q(hold_q),
        .act_set_a(act_set_a), .act_rst_a(act_rst_a),
        .act_set_b(act_set_b), .act_rst_b(act_rst_b),
        .act_cfg(act_cfg), .act_mode(act_mode)
    );
endmodule

// File: rtl/pwm_shadow_ctrl_chk.sv
// Checker: temporal properties of the shadow update controller,
// attached to every instance of the top module by bind.
module pwm_shadow_ctrl_chk #(
    parameter int CMP_W  = 12,
    parameter int CFG_W  = 4,
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic              run,
    input logic              eoc,
    input logic              xfer,
    input logic              lock_q,
    input logic              al_eff_q,
    input logic              pend_q,
    input logic              mirror_q,
    input logic [CMP_W-1:0]  act_set_a,
    input logic [CMP_W-1:0]  act_rst_a,
    input logic [CMP_W-1:0]  act_set_b,
    input logic [CMP_W-1:0]  act_rst_b,
    input logic [CFG_W-1:0]  act_cfg,
    input logic [MODE_W-1:0] act_mode
);
    AST_QUIET_MID_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !eoc) |=> ($stable(act_set_b) && $stable(act_rst_b) && $stable(act_cfg) && $stable(act_mode))); // R4
    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && eoc && lock_q && !al_eff_q) |=> ($stable(act_set_b) && $stable(act_rst_b) && $stable(act_cfg))); // R5
    AST_ALOCK_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && eoc && al_eff_q && !pend_q) |=> ($stable(act_set_b) && $stable(act_rst_b) && $stable(act_mode))); // R6
    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !(wr_en && wr_addr == 4'd7)) |=> !pend_q); // R11
    AST_MIRROR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        mirror_q |-> (act_set_a == act_set_b && act_rst_a == act_rst_b)); // R9
    AST_STOP_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && wr_en && wr_addr == 4'd8) |=> (act_cfg == $past(wr_data[CFG_W-1:0]))); // R3
endmodule

bind pwm_shadow_ctrl pwm_shadow_ctrl_chk #(.CMP_W(CMP_W), .CFG_W(CFG_W), .MODE_W(MODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .eoc(eoc), .xfer(xfer), .lock_q(lock_q), .al_eff_q(al_eff_q),
    .pend_q(pend_q), .mirror_q(mirror_q),
    .act_set_a(act_set_a), .act_rst_a(act_rst_a), .act_set_b(act_set_b),
    .act_rst_b(act_rst_b), .act_cfg(act_cfg), .act_mode(act_mode)
);

// File: tb/pwm_shadow_ctrl_test.sv
// Bench: directed script plus a behavioural reference compared every clock.
module pwm_shadow_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        run = 1'b0;
    logic        eoc = 1'b0;
    logic [11:0] act_set_a, act_rst_a, act_set_b, act_rst_b;
    logic [3:0]  act_cfg;
    logic [1:0]  act_mode;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    string phase = "R1";

    pwm_shadow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run(run), .eoc(eoc),
        .act_set_a(act_set_a), .act_rst_a(act_rst_a), .act_set_b(act_set_b),
        .act_rst_b(act_rst_b), .act_cfg(act_cfg), .act_mode(act_mode)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Reference model state (integers, field order 0..5 as in R2).
    int m_hold [6];
    int m_act  [6];
    int m_lo   [4];
    bit m_lock, m_al, m_mir, m_ale, m_pend;
    bit m_xf, m_al_old;
    int m_v, m_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_hold[i]) begin m_hold[i] = 0; m_act[i] = 0; end
            foreach (m_lo[i]) m_lo[i] = 0;
            m_lock = 0; m_al = 0; m_mir = 0; m_ale = 0; m_pend = 0;
        end else begin
            m_al_old = m_al;
            m_xf = run && eoc && (m_ale ? m_pend : !m_lock);
            if (m_xf) foreach (m_act[i]) m_act[i] = m_hold[i];
            if (wr_en) begin
                m_idx = -1;
                if (wr_addr < 8) begin
                    if (!wr_addr[0]) m_lo[wr_addr / 2] = int'(wr_data);
                    else begin
                        m_idx = wr_addr / 2;
                        m_v = (int'(wr_data) % 16) * 256 + m_lo[m_idx];
                    end
                end else if (wr_addr == 8) begin m_idx = 4; m_v = int'(wr_data) % 16; end
                else if (wr_addr == 9) begin m_idx = 5; m_v = int'(wr_data) % 4; end
                else if (wr_addr == 10) begin
                    m_lock = wr_data[0]; m_al = wr_data[1]; m_mir = wr_data[2];
                end
                if (m_idx >= 0) begin
                    m_hold[m_idx] = m_v;
                    if (!run) m_act[m_idx] = m_v;
                end
            end
            if (m_xf) m_pend = 0;
            if (run && wr_en && wr_addr == 7) m_pend = 1;
            if (eoc) m_ale = m_al_old;
        end
    end

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Compare every output with the model each clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({phase, " set_a"}, int'(act_set_a), m_mir ? m_act[2] : m_act[0]);
            check({phase, " rst_a"}, int'(act_rst_a), m_mir ? m_act[3] : m_act[1]);
            check({phase, " set_b"}, int'(act_set_b), m_act[2]);
            check({phase, " rst_b"}, int'(act_rst_b), m_act[3]);
            check({phase, " cfg"},   int'(act_cfg),   m_act[4]);
            check({phase, " mode"},  int'(act_mode),  m_act[5]);
        end
    end

    task automatic tick(input bit we, input logic [3:0] a, input logic [7:0] d, input bit e);
        wr_en = we; wr_addr = a; wr_data = d; eoc = e;
        @(negedge clk);
        wr_en = 1'b0; eoc = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        tick(1'b1, a, d, 1'b0);
    endtask

    task automatic pulse();
        tick(1'b0, 4'd0, 8'd0, 1'b1);
    endtask

    task automatic wr12(input int k, input int v);
        wr(4'(2 * k), 8'(v % 256));
        wr(4'(2 * k + 1), 8'(v / 256));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: everything clear after reset
        check("R1", int'(act_set_a) + int'(act_rst_b) + int'(act_cfg) + int'(act_mode), 0);

        // R2 / R3: stopped writes
        phase = "R3";
        wr(4'd0, 8'h23);
        check("R2 low byte alone", int'(act_set_a), 0);
        wr(4'd1, 8'h01);
        check("R3 stopped commit", int'(act_set_a), 'h123);
        wr(4'd8, 8'h05);
        check("R3 stopped cfg", int'(act_cfg), 5);
        pulse();
        check("R3 eoc ignored stopped", int'(act_set_a), 'h123);

        // R4: running, no lock
        phase = "R4";
        run = 1'b1;
        wr12(3, 'hABC);
        wr12(2, 'h456);
        repeat (3) @(negedge clk);
        check("R4 held mid-cycle", int'(act_rst_b), 0);
        pulse();
        check("R4 rst_b at eoc", int'(act_rst_b), 'hABC);
        check("R4 set_b at eoc", int'(act_set_b), 'h456);

        // R5: lock
        phase = "R5";
        wr(4'd10, 8'h01);
        wr12(0, 'h777);
        pulse();
        check("R5 locked", int'(act_set_a), 'h123);
        wr(4'd10, 8'h00);
        check("R5 before eoc", int'(act_set_a), 'h123);
        pulse();
        check("R5 released", int'(act_set_a), 'h777);

        // R8: first eoc after enabling auto-lock uses old policy
        phase = "R8";
        wr(4'd10, 8'h02);
        wr(4'd9, 8'h03);
        pulse();
        check("R8 first eoc old policy", int'(act_mode), 3);

        // R6: auto-lock waits for reset-B high write
        phase = "R6";
        wr12(0, 'h0AA);
        pulse();
        check("R6 no trigger", int'(act_set_a), 'h777);
        wr12(3, 'h321);
        check("R6 waits for eoc", int'(act_rst_b), 'hABC);
        pulse();
        check("R6 triggered set_a", int'(act_set_a), 'h0AA);
        check("R6 triggered rst_b", int'(act_rst_b), 'h321);

        // R11: pending cleared after transfer
        phase = "R11";
        wr12(2, 'h999);
        pulse();
        check("R11 no second transfer", int'(act_set_b), 'h456);

        // R7: auto-lock beats lock
        phase = "R7";
        wr(4'd10, 8'h03);
        wr12(3, 'h222);
        pulse();
        check("R7 lock ignored set_b", int'(act_set_b), 'h999);
        check("R7 lock ignored rst_b", int'(act_rst_b), 'h222);

        // R10: write coinciding with transfer
        phase = "R10";
        wr(4'd10, 8'h00);
        pulse();  // auto-lock dropped here, no pending -> no transfer
        wr12(2, 'h888);
        wr(4'd6, 8'h55);
        tick(1'b1, 4'd7, 8'h04, 1'b1);
        check("R10 old set carried", int'(act_set_b), 'h888);
        check("R10 new value waits", int'(act_rst_b), 'h222);
        pulse();
        check("R10 later transfer", int'(act_rst_b), 'h455);

        // R9: mirror
        phase = "R9";
        wr(4'd10, 8'h04);
        check("R9 set_a mirrors", int'(act_set_a), 'h888);
        check("R9 rst_a mirrors", int'(act_rst_a), 'h455);
        wr(4'd10, 8'h00);
        check("R9 mirror off", int'(act_set_a), 'h0AA);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule